// File: doc/BRIEF.md
# Two-Level DMA Page-Table Walker

This block translates a 32-bit device virtual address, issued on behalf of one stream, into a physical address. It reads a two-level translation table from system memory through a 64-bit read port that may stall and may return data after any number of cycles. It then checks the access against the byte window stored in the leaf entry. It returns either the physical address or a fault cause. The cause is one-hot coded so that an error-status register can latch it unchanged.

A request carries the stream id, the virtual address and the direction. It also carries two values from the register block: the stream's translation-enable bit and the stream's table base, given as a valid bit and a physical page number. Pages are 16 KiB and every table page holds 2048 entries of 8 bytes. So VA[31:25] selects the level-1 slot, VA[24:14] selects the leaf slot, and VA[13:0] is the byte offset within the page.

A leaf holds a permitted sub-page window, in 4-byte units of the in-page offset. The mapping software trims the first page's window start down to an 8-byte boundary. It ends the last partial page at the length rounded up to 8 bytes, minus one. An access outside the window faults even though the page itself is mapped. The walker serves one request at a time and gives exactly one response for each request.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. It is high after reset. A request is taken when `req_valid` and `req_ready` are both high. While a walk is in progress, `req_valid` and changes on the request inputs have no effect.
- R2: If a request is taken while `xlat_en` is 0 or `tbl_valid` is 0, the walker issues no memory read. The response appears in the very next cycle with fault code 5'b00001 (no table base).
- R3: The first memory read fetches the level-1 entry at byte address `tbl_page`·16384 + VA[31:25]·8. If that entry's bits [1:0] are not 2'b11, the walker issues no further read and responds with fault 5'b00010 (no level-1 entry).
- R4: The second read fetches the leaf at byte address (level-1 entry bits [PA_W-1:14])·16384 + VA[24:14]·8.
- R5: A leaf whose bit 0 is clear (including the all-zero leaf) gives fault 5'b00100 (no leaf), whatever its other bits hold.
- R6: On success the fault is 5'b00000 and `rsp_pa` = {leaf bits [PA_W-1:14], VA[13:0]}.
- R7: The window check applies when leaf bit 1 is clear. Leaf bits [63:52] give the lowest allowed value of VA[13:2] and bits [51:40] the highest, both bounds inclusive. An access below or above the window faults with 5'b01000 for a write (`req_wr`=1) or 5'b10000 for a read.
- R8: When leaf bit 1 (full page) is set, the window fields have no effect and any offset in the page translates.
- R9: Each taken request yields exactly one `rsp_valid` pulse of one cycle. The pulse echoes the request's stream id, carries at most one fault bit, and has `rsp_pa` = 0 whenever a fault is reported.
- R10: `mem_req_valid` with an unchanged `mem_req_addr` is held until `mem_req_ready` is seen high. Any number of stall cycles on either the request or the return side gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_sid | input | SID_W | Stream id of the request |
| req_va | input | VA_W | Device virtual address |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| xlat_en | input | 1 | Translation enabled for this stream |
| tbl_valid | input | 1 | Table base present for this stream |
| tbl_page | input | PA_W-14 | Physical page number of the level-1 table |
| mem_req_valid | output | 1 | 64-bit memory read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned entry |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 5 | One-hot fault cause, 0 on success |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_sid | output | SID_W | Stream id of the answered request |

## Verification
The checks assume that the memory side answers each accepted read exactly once, no earlier than the cycle after acceptance, and never sends `mem_rsp_valid` while no read is outstanding. They also assume that `rsp_valid` needs no acknowledgement. The bench's memory model follows these rules. It raises `mem_req_ready` only after it has seen `mem_req_valid`, and it returns data after a programmable stall of zero to three cycles on each side. Requests are issued only while the walker is idle, except in one run where `req_valid` and the request fields are deliberately changed during a walk.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
// ptw_pkg: constants, fault codes and state type shared by the table walker.
// Assumes 16 KiB pages and 8-byte table entries.
package ptw_pkg;
    localparam int PG_SH      = 14;              // log2 of page size
    localparam int ENT_SH     = 3;               // log2 of entry size
    localparam int IDX_W      = PG_SH - ENT_SH;  // entries per table page: 2048
    localparam int FLT_W      = 5;
    localparam int WIN_W      = PG_SH - 2;       // window in 4-byte units
    localparam int WIN_LO_LSB = 52;              // lowest allowed unit
    localparam int WIN_HI_LSB = 40;              // highest allowed unit

    typedef logic [FLT_W-1:0] flt_t;

    // One-hot causes; bit positions are decoded by the error-status register
    localparam flt_t FLT_NONE    = 5'b00000;
    localparam flt_t FLT_NO_TBL  = 5'b00001;
    localparam flt_t FLT_NO_L1   = 5'b00010;
    localparam flt_t FLT_NO_LEAF = 5'b00100;
    localparam flt_t FLT_WR      = 5'b01000;
    localparam flt_t FLT_RD      = 5'b10000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_CHECK,
        ST_RESP
    } walk_st_e;
endpackage

// File: rtl/ptw_index.sv
`timescale 1ns/1ps
// ptw_index: forms the byte addresses of the level-1 slot and the leaf slot.
// Assumes the level-1 index (VA_W-25 bits) fits inside one table page.
module ptw_index
    import ptw_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PA_W = 36
) (
    input  logic [VA_W-1:PG_SH]  va_pg,
    input  logic [PA_W-PG_SH-1:0] tbl_page,
    input  logic [PA_W-PG_SH-1:0] l2_page,
    output logic [PA_W-1:0]      l1_addr,
    output logic [PA_W-1:0]      l2_addr
);
    localparam int L1_W = VA_W - PG_SH - IDX_W;

    logic [L1_W-1:0]  l1_idx;
    logic [IDX_W-1:0] l2_idx;

    // split the virtual page number into the two table indices
    assign l1_idx = va_pg[VA_W-1:PG_SH+IDX_W];
    assign l2_idx = va_pg[PG_SH+IDX_W-1:PG_SH];

    // slot address = table page base plus index times entry size
    assign l1_addr = {tbl_page, {PG_SH{1'b0}}} | (PA_W'(l1_idx) << ENT_SH);
    assign l2_addr = {l2_page,  {PG_SH{1'b0}}} | (PA_W'(l2_idx) << ENT_SH);
endmodule

// File: rtl/ptw_leaf_chk.sv
`timescale 1ns/1ps
// ptw_leaf_chk: judges a fetched leaf against the in-page offset and builds
// the physical address. Assumes PA_W < 40 so page bits stay below the window.
module ptw_leaf_chk
    import ptw_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [63:0]      leaf,
    input  logic [PG_SH-1:0] off,
    input  logic             is_wr,
    output flt_t             fault,
    output logic [PA_W-1:0]  pa
);
    logic [WIN_W-1:0] unit_idx;
    logic [WIN_W-1:0] win_lo;
    logic [WIN_W-1:0] win_hi;
    logic             outside;
    logic             unused_leaf;

    assign unit_idx    = off[PG_SH-1:2];
    assign win_lo      = leaf[WIN_LO_LSB +: WIN_W];
    assign win_hi      = leaf[WIN_HI_LSB +: WIN_W];
    assign outside     = (unit_idx < win_lo) || (unit_idx > win_hi);
    assign unused_leaf = ^{leaf[WIN_HI_LSB-1:PA_W], leaf[PG_SH-1:2]};

    // pick the cause: missing leaf first, then window violation by direction
    always_comb begin
        if (!leaf[0]) begin
            fault = FLT_NO_LEAF;
        end else if (!leaf[1] && outside) begin
            fault = is_wr ? FLT_WR : FLT_RD;
        end else begin
            fault = FLT_NONE;
        end
    end

    // the address is only meaningful on success; otherwise zero
    assign pa = (fault == FLT_NONE) ? {leaf[PA_W-1:PG_SH], off} : '0;
endmodule

// File: rtl/ptw_ctrl.sv
`timescale 1ns/1ps
// ptw_ctrl: sequencer of the walk. Assumes every accepted memory read returns
// exactly once, at least one cycle after acceptance.
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       walk_ok,
    input  logic       mem_req_ready,
    input  logic       mem_rsp_valid,
    input  logic [1:0] rsp_type,
    output logic       req_ready,
    output logic       mem_req_valid,
    output logic       sel_l2,
    output logic       take_req,
    output logic       take_l1,
    output logic       l1_bad,
    output logic       take_leaf,
    output logic       do_check,
    output logic       rsp_valid
);
    walk_st_e st, st_nx;
    logic     l1_ok;

    assign l1_ok = (rsp_type == 2'b11);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state decision
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:    if (req_valid)     st_nx = walk_ok ? ST_L1_REQ : ST_RESP;
            ST_L1_REQ:  if (mem_req_ready) st_nx = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) st_nx = l1_ok ? ST_L2_REQ : ST_RESP;
            ST_L2_REQ:  if (mem_req_ready) st_nx = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) st_nx = ST_CHECK;
            ST_CHECK:   st_nx = ST_RESP;
            ST_RESP:    st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    assign req_ready     = (st == ST_IDLE);
    assign take_req      = req_ready && req_valid;
    assign mem_req_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
    assign sel_l2        = (st == ST_L2_REQ);
    assign take_l1       = (st == ST_L1_WAIT) && mem_rsp_valid;
    assign l1_bad        = take_l1 && !l1_ok;
    assign take_leaf     = (st == ST_L2_WAIT) && mem_rsp_valid;
    assign do_check      = (st == ST_CHECK);
    assign rsp_valid     = (st == ST_RESP);
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
// ptw_walker: two-level table walk for one stream request at a time.
// Captures the request on acceptance, fetches the level-1 slot and the leaf
// through a stallable 64-bit read port, checks the leaf window and presents
// one response pulse. Assumes the read port answers each accepted read once.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int SID_W = 4,
    parameter int VA_W  = 32,
    parameter int PA_W  = 36
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [SID_W-1:0]      req_sid,
    input  logic [VA_W-1:0]       req_va,
    input  logic                  req_wr,
    input  logic                  xlat_en,
    input  logic                  tbl_valid,
    input  logic [PA_W-PG_SH-1:0] tbl_page,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [PA_W-1:0]       mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [63:0]           mem_rsp_data,
    output logic                  rsp_valid,
    output logic [FLT_W-1:0]      rsp_fault,
    output logic [PA_W-1:0]       rsp_pa,
    output logic [SID_W-1:0]      rsp_sid
);
    localparam int PG_W = PA_W - PG_SH;

    logic             walk_ok;
    logic             sel_l2, take_req, take_l1, l1_bad, take_leaf, do_check;
    logic [VA_W-1:0]  va_q;
    logic             wr_q;
    logic [SID_W-1:0] sid_q;
    logic [PG_W-1:0]  page_q;
    logic [PG_W-1:0]  l2pg_q;
    logic [63:0]      leaf_q;
    flt_t             fault_q;
    logic [PA_W-1:0]  pa_q;
    logic [PA_W-1:0]  l1_addr, l2_addr;
    flt_t             chk_fault;
    logic [PA_W-1:0]  chk_pa;

    assign walk_ok = xlat_en && tbl_valid;

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .walk_ok       (walk_ok),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_type      (mem_rsp_data[1:0]),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .sel_l2        (sel_l2),
        .take_req      (take_req),
        .take_l1       (take_l1),
        .l1_bad        (l1_bad),
        .take_leaf     (take_leaf),
        .do_check      (do_check),
        .rsp_valid     (rsp_valid)
    );

    ptw_index #(.VA_W(VA_W), .PA_W(PA_W)) u_index (
        .va_pg    (va_q[VA_W-1:PG_SH]),
        .tbl_page (page_q),
        .l2_page  (l2pg_q),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr)
    );

    ptw_leaf_chk #(.PA_W(PA_W)) u_leaf (
        .leaf  (leaf_q),
        .off   (va_q[PG_SH-1:0]),
        .is_wr (wr_q),
        .fault (chk_fault),
        .pa    (chk_pa)
    );

    // hold the accepted request for the whole walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            wr_q   <= 1'b0;
            sid_q  <= '0;
            page_q <= '0;
        end else if (take_req) begin
            va_q   <= req_va;
            wr_q   <= req_wr;
            sid_q  <= req_sid;
            page_q <= tbl_page;
        end
    end

    // keep the level-2 table page and the leaf returned by memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l2pg_q <= '0;
            leaf_q <= '0;
        end else begin
            if (take_l1)   l2pg_q <= mem_rsp_data[PA_W-1:PG_SH];
            if (take_leaf) leaf_q <= mem_rsp_data;
        end
    end

    // result register: set by whichever stage ends the walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= FLT_NONE;
            pa_q    <= '0;
        end else if (take_req) begin
            fault_q <= walk_ok ? FLT_NONE : FLT_NO_TBL;
            pa_q    <= '0;
        end else if (l1_bad) begin
            fault_q <= FLT_NO_L1;
        end else if (do_check) begin
            fault_q <= chk_fault;
            pa_q    <= chk_pa;
        end
    end

    assign mem_req_addr = sel_l2 ? l2_addr : l1_addr;
    assign rsp_fault    = fault_q;
    assign rsp_pa       = pa_q;
    assign rsp_sid      = sid_q;
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
// ptw_walker_chk: protocol and result properties of the walker, bound to it.
// Assumes the memory side answers each accepted read exactly once.
module ptw_walker_chk #(
    parameter int SID_W = 4,
    parameter int PA_W  = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SID_W-1:0] req_sid,
    input logic [13:0]      req_off,
    input logic             xlat_en,
    input logic             tbl_valid,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             rsp_valid,
    input logic [4:0]       rsp_fault,
    input logic [PA_W-1:0]  rsp_pa,
    input logic [SID_W-1:0] rsp_sid
);
    logic [13:0]      off_h;
    logic [SID_W-1:0] sid_h;

    // remember the accepted request's offset and stream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_h <= '0;
            sid_h <= '0;
        end else if (req_valid && req_ready) begin
            off_h <= req_off;
            sid_h <= req_sid;
        end
    end

    a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !rsp_valid));

    a_r2_disabled_fast_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(xlat_en && tbl_valid))
        |=> (rsp_valid && rsp_fault == 5'b00001 && !mem_req_valid));

    a_r3_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 5'b00000) |-> (rsp_pa[13:0] == off_h));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_onehot_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0(rsp_fault));

    a_r9_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 5'b00000) |-> (rsp_pa == '0));

    a_r9_sid_echo: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_sid == sid_h));

    a_r10_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind ptw_walker ptw_walker_chk #(.SID_W(SID_W), .PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_sid       (req_sid),
    .req_off       (req_va[13:0]),
    .xlat_en       (xlat_en),
    .tbl_valid     (tbl_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_pa        (rsp_pa),
    .rsp_sid       (rsp_sid)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
// ptw_walker_tb: behavioural model of the table walk plus a stallable memory.
module ptw_walker_tb;
    localparam int SID_W = 4;
    localparam int VA_W  = 32;
    localparam int PA_W  = 36;
    localparam int PG_W  = PA_W - 14;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid, req_ready, req_wr, xlat_en, tbl_valid;
    logic [SID_W-1:0] req_sid;
    logic [VA_W-1:0]  req_va;
    logic [PG_W-1:0]  tbl_page;
    logic             mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [PA_W-1:0]  mem_req_addr;
    logic [63:0]      mem_rsp_data;
    logic             rsp_valid;
    logic [4:0]       rsp_fault;
    logic [PA_W-1:0]  rsp_pa;
    logic [SID_W-1:0] rsp_sid;

    always #4 clk = ~clk;

    ptw_walker #(.SID_W(SID_W), .VA_W(VA_W), .PA_W(PA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_sid(req_sid),
        .req_va(req_va), .req_wr(req_wr), .xlat_en(xlat_en),
        .tbl_valid(tbl_valid), .tbl_page(tbl_page),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .rsp_sid(rsp_sid)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int rdy_dly = 0;
    int rsp_dly = 0;
    bit busy = 0;
    bit run = 0;

    logic [63:0]      mem_img [logic [PA_W-1:0]];
    logic [PA_W-1:0]  q_rd[$];
    string            q_rd_tag[$];
    logic [4:0]       q_flt[$];
    logic [PA_W-1:0]  q_pa[$];
    logic [SID_W-1:0] q_sid[$];
    string            q_tag[$];

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
        return mem_img.exists(a) ? mem_img[a] : 64'd0;
    endfunction

    function automatic logic [PA_W-1:0] slot(input logic [PA_W-1:0] tbl, input longint idx);
        return tbl + PA_W'(idx * 8);
    endfunction

    // window fields hold the 4-byte unit of the first and last allowed byte
    function automatic logic [63:0] mk_leaf(input logic [PA_W-1:0] pg, input int lo,
                                            input int hi, input bit full);
        logic [63:0] v;
        v = 64'(pg) | 64'd1;
        v = v | (64'(lo / 4) << 52) | (64'(hi / 4) << 40);
        if (full) v = v | 64'd2;
        return v;
    endfunction

    // behavioural model: expected reads and the expected response
    task automatic expect_walk(input logic [SID_W-1:0] sid, input logic [31:0] va,
                               input logic wr, input logic en, input logic tv,
                               input logic [PG_W-1:0] pg, input string tag);
        logic [PA_W-1:0] a1, a2, pa;
        logic [63:0]     e1, lf;
        logic [4:0]      f;
        int              unit, lo, hi;
        pa = '0;
        if (!(en && tv)) begin
            f = 5'b00001;
        end else begin
            a1 = slot(PA_W'(pg) * PA_W'(16384), longint'(va / 32'h0200_0000));
            q_rd.push_back(a1); q_rd_tag.push_back("R3");
            e1 = rd(a1);
            if (e1[1:0] != 2'b11) begin
                f = 5'b00010;
            end else begin
                a2 = slot(e1[PA_W-1:0] & ~PA_W'(16383), longint'((va / 16384) % 2048));
                q_rd.push_back(a2); q_rd_tag.push_back("R4");
                lf = rd(a2);
                unit = int'(va % 16384) / 4;
                lo   = int'(lf[63:52]);
                hi   = int'(lf[51:40]);
                if (!lf[0]) f = 5'b00100;
                else if (!lf[1] && (unit < lo || unit > hi)) f = wr ? 5'b01000 : 5'b10000;
                else begin
                    f  = 5'b00000;
                    pa = (lf[PA_W-1:0] & ~PA_W'(16383)) | PA_W'(va % 16384);
                end
            end
        end
        q_flt.push_back(f); q_pa.push_back(pa); q_sid.push_back(sid); q_tag.push_back(tag);
    endtask

    // drive one request; with hold, keep req_valid up and scramble fields (R1)
    task automatic issue(input logic [SID_W-1:0] sid, input logic [31:0] va, input logic wr,
                         input logic en, input logic tv, input logic [PG_W-1:0] pg,
                         input string tag, input bit hold);
        expect_walk(sid, va, wr, en, tv, pg, tag);
        @(negedge clk);
        req_valid = 1'b1; req_sid = sid; req_va = va; req_wr = wr;
        xlat_en = en; tbl_valid = tv; tbl_page = pg;
        @(posedge clk);
        busy = 1'b1;
        @(negedge clk);
        if (hold) begin
            req_va = ~va; req_sid = ~sid; xlat_en = 1'b0; req_wr = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        wait (!busy);
        req_valid = 1'b0;
    endtask

    // memory model: checks read addresses, stalls ready and data (R10)
    initial begin
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rst_n === 1'b1 && mem_req_valid === 1'b1) begin : serve
                logic [PA_W-1:0] a;
                a = mem_req_addr;
                if (q_rd.size() == 0) begin
                    chk("R2", "unexpected memory read", 64'(a), 64'hFFFF_FFFF_FFFF_FFFF);
                end else begin
                    chk(q_rd_tag.pop_front(), "read address", 64'(a), 64'(q_rd.pop_front()));
                end
                repeat (rdy_dly) @(negedge clk);
                chk("R10", "address held while stalled", 64'(mem_req_addr), 64'(a));
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (rsp_dly) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(a);
            end
        end
    end

    // per-clock comparison of ready and responses against the model
    initial begin
        forever begin
            @(negedge clk);
            if (run && rst_n === 1'b1) begin
                chk("R1", "req_ready", 64'(req_ready), 64'(!busy));
                if (rsp_valid === 1'b1) begin
                    if (q_flt.size() == 0) begin
                        chk("R9", "response without request", 64'(rsp_valid), 64'd0);
                    end else begin : cmp
                        string t;
                        t = q_tag.pop_front();
                        chk(t, "rsp_fault", 64'(rsp_fault), 64'(q_flt.pop_front()));
                        chk(t, "rsp_pa", 64'(rsp_pa), 64'(q_pa.pop_front()));
                        chk("R9", "rsp_sid", 64'(rsp_sid), 64'(q_sid.pop_front()));
                        chk(t, "reads left at response", 64'(q_rd.size()), 64'd0);
                    end
                    busy = 1'b0;
                end
            end
        end
    end

    // watchdog: a hang counts as a failure and still ends with the summary
    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL R9 watchdog: got no completion expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    localparam logic [PG_W-1:0] TB_PG  = 22'h000400;       // level-1 table at 0x100_0000
    localparam logic [PA_W-1:0] T2     = 36'h0_0110_0000;  // level-2 table
    localparam logic [PA_W-1:0] T1     = 36'h0_0100_0000;
    localparam logic [31:0]     VA_A   = 32'h0204_5678;    // full-page leaf
    localparam logic [31:0]     VA_B   = 32'h0204_8000;    // windowed leaf page
    localparam logic [31:0]     VA_C   = 32'h0400_0000;    // empty level-1 slot
    localparam logic [31:0]     VA_D   = 32'h0600_0000;    // malformed level-1 slot
    localparam logic [31:0]     VA_E   = 32'h0208_0000;    // empty leaf
    localparam logic [31:0]     VA_F   = 32'h0208_4000;    // leaf with bit 0 clear

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_sid = '0; req_va = '0; req_wr = 1'b0;
        xlat_en = 1'b0; tbl_valid = 1'b0; tbl_page = '0;

        mem_img[slot(T1, 1)]    = 64'(T2) | 64'd3;
        mem_img[slot(T1, 3)]    = 64'(T2) | 64'd1;
        mem_img[slot(T2, 17)]   = mk_leaf(36'h8_1234_4000, 14'h3000, 14'h0100, 1'b1);
        mem_img[slot(T2, 18)]   = mk_leaf(36'h0_7777_8000, 14'h0018, 14'h1237, 1'b0);
        mem_img[slot(T2, 33)]   = 64'h0003_0000_0001_4002;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk("R9", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R10", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        run = 1'b1;

        // R2: translation off, then table base missing
        issue(4'h1, VA_A, 1'b0, 1'b0, 1'b1, TB_PG, "R2", 1'b0);
        issue(4'h2, VA_A, 1'b1, 1'b1, 1'b0, TB_PG, "R2", 1'b0);
        // R3: empty and malformed level-1 slots
        issue(4'h3, VA_C, 1'b0, 1'b1, 1'b1, TB_PG, "R3", 1'b0);
        issue(4'h4, VA_D, 1'b1, 1'b1, 1'b1, TB_PG, "R3", 1'b0);
        // R5: zero leaf, and nonzero leaf with bit 0 clear
        issue(4'h5, VA_E, 1'b0, 1'b1, 1'b1, TB_PG, "R5", 1'b0);
        issue(4'h6, VA_F, 1'b1, 1'b1, 1'b1, TB_PG, "R5", 1'b0);
        // R8 / R6: full page ignores a window that would exclude the offset
        issue(4'h7, VA_A, 1'b0, 1'b1, 1'b1, TB_PG, "R8", 1'b0);
        issue(4'h8, VA_A | 32'h3FFC, 1'b1, 1'b1, 1'b1, TB_PG, "R6", 1'b0);
        // R7: window bounds 0x18..0x1237, both directions
        issue(4'h9, VA_B | 32'h0018, 1'b0, 1'b1, 1'b1, TB_PG, "R7", 1'b0);
        issue(4'hA, VA_B | 32'h0014, 1'b0, 1'b1, 1'b1, TB_PG, "R7", 1'b0);
        issue(4'hB, VA_B | 32'h0014, 1'b1, 1'b1, 1'b1, TB_PG, "R7", 1'b0);
        issue(4'hC, VA_B | 32'h1237, 1'b1, 1'b1, 1'b1, TB_PG, "R7", 1'b0);
        issue(4'hD, VA_B | 32'h1238, 1'b1, 1'b1, 1'b1, TB_PG, "R7", 1'b0);
        issue(4'hE, VA_B | 32'h1238, 1'b0, 1'b1, 1'b1, TB_PG, "R7", 1'b0);
        // R1: request inputs change during walks and must be ignored
        issue(4'h3, VA_B | 32'h0100, 1'b0, 1'b1, 1'b1, TB_PG, "R1", 1'b1);
        issue(4'h5, VA_C, 1'b1, 1'b1, 1'b1, TB_PG, "R1", 1'b1);
        // R10: every combination of request and return stalls
        for (int r = 0; r < 4; r++) begin
            for (int d = 0; d < 4; d++) begin
                rdy_dly = r; rsp_dly = d;
                issue(4'(r * 4 + d), VA_A + 32'(r * 64 + d * 8), 1'(d % 2), 1'b1, 1'b1,
                      TB_PG, "R10", 1'b0);
            end
        end
        rdy_dly = 2; rsp_dly = 3;
        issue(4'hF, VA_D, 1'b0, 1'b1, 1'b1, TB_PG, "R10", 1'b0);
        issue(4'h0, VA_B | 32'h2000, 1'b1, 1'b1, 1'b1, TB_PG, "R10", 1'b0);

        repeat (5) @(negedge clk);
        chk("R9", "responses outstanding", 64'(q_flt.size()), 64'd0);
        chk("R9", "reads outstanding", 64'(q_rd.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule